// File: doc/BRIEF.md
# Bit-Timing Recovery Loop with Fast Acquisition

This block recovers the bit clock from a stream of sliced receive data delivered at sixteen samples per bit. A four-bit phase counter advances once per valid sample and wraps once per bit. The block raises a one-cycle bit strobe when the counter passes the bit centre, and on that strobe it registers the recovered data bit.

Every level change in the sliced input is taken as a bit boundary. The counter's signed distance from zero at that sample is the phase error. A scaled share of that error is removed from the counter. A two-bit bandwidth field picks the scaling: medium, wide or narrow. A fourth setting, hold, stops all corrections so the loop free-runs through a fade.

A control write whose acquire bit is 0 starts a self-timed acquisition. The loop first snaps its phase fully onto each edge. It then halves its gain step by step until it reaches the programmed bandwidth. A busy flag is high for the whole sequence.

Top module: `bsync_dpll`

## Requirements
- R1: The phase counter advances by one on each cycle with `smp_vld` high and holds otherwise. With no corrections, `bit_stb` is a one-cycle pulse once every 16 valid samples. It is raised in the cycle after a valid sample taken at phase 8.
- R2: `bit_data` takes the value of `rx_in` from the sample that caused the strobe, and changes at no other time.
- R3: A transition is a valid sample whose `rx_in` differs from the previous valid sample; the previous value resets to 0. On a transition at phase p, the error e is p read as 4-bit two's complement. The counter's next value is p + 1 − sign(e)·max(1, |e| >> s), or p + 1 when e = 0. The shift s is 1 for wide, 2 for medium and 3 for narrow.
- R4: The bandwidth field `ctl_wdata[1:0]` encodes 00 medium, 01 wide, 10 narrow and 11 hold. In hold, outside acquisition, transitions cause no correction.
- R5: Reset clears the strobe, data bit, busy flag and phase counter, and sets the bandwidth to medium with no acquisition running.
- R6: A cycle with `ctl_we` high writes `ctl_wdata[1:0]` to the bandwidth field. If `ctl_wdata[2]` is 0 in that write, `acq_busy` is high in the next cycle and any running acquisition restarts from its first step. A write with `ctl_wdata[2]` = 1 leaves `acq_busy` unchanged.
- R7: During the first 4 transitions of an acquisition the shift is 0. This is a full snap, so the next strobe follows 8 valid samples after such a transition.
- R8: After those 4 transitions, the acquisition shift rises by one after every 8 further transitions. `acq_busy` falls on the transition that brings the shift to the programmed one. This happens on transition 4 for wide, transition 12 for medium and transition 20 for narrow.
- R9: With hold programmed, acquisition runs through narrow and ends on transition 20. Afterwards transitions cause no correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | Qualifies one sample of `rx_in` (16 per bit) |
| rx_in | input | 1 | Sliced receive data sample |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | [1:0] bandwidth field, [2] acquire command (0 starts) |
| bit_stb | output | 1 | One-cycle bit-centre strobe |
| bit_data | output | 1 | Recovered data bit, updated on each strobe |
| acq_busy | output | 1 | High while the acquisition sequence runs |

## Verification
The bound checker watches five rules on every cycle: strobes are isolated, idle cycles freeze the phase, the data bit changes only with a strobe, a zero acquire bit always raises busy, and a one leaves an idle loop idle. It also checks that in hold the phase steps by exactly one per sample, and that busy only ever falls on a transition. The exact size of each correction is left to the bench. So is the full snap during acquisition, and the number of transitions each bandwidth needs before busy drops. The bench sweeps all sixteen edge phases in every bandwidth setting and measures the distance to the next strobe.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

  localparam int SH_W = 2;

  typedef enum logic [1:0] {
    BW_MEDIUM = 2'b00,
    BW_WIDE   = 2'b01,
    BW_NARROW = 2'b10,
    BW_HOLD   = 2'b11
  } bw_e;

  // Shift that a bandwidth setting asks for; hold maps to the narrow shift
  // so that acquisition has a final stage to reach.
  function automatic logic [SH_W-1:0] bw_shift(input bw_e bw);
    case (bw)
      BW_WIDE:   bw_shift = 2'd1;
      BW_MEDIUM: bw_shift = 2'd2;
      default:   bw_shift = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/bsync_edge.sv
module bsync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld,
  input  logic rx_in,
  output logic trn
);

  logic prev_q, prev_d;

  always_comb begin
    prev_d = prev_q;
    if (smp_vld) prev_d = rx_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign trn = smp_vld && (rx_in != prev_q);

endmodule

// File: rtl/bsync_step.sv
module bsync_step #(
  parameter int PH_W = 4,
  parameter int SH_W = 2
) (
  input  logic [PH_W-1:0] ph,
  input  logic            apply,
  input  logic [SH_W-1:0] shift,
  output logic [PH_W-1:0] delta
);

  localparam int MW = PH_W + 1;

  logic            neg;
  logic [MW-1:0]   mag, mag_sh;
  logic [PH_W-1:0] st;

  always_comb begin
    neg    = ph[PH_W-1];
    mag    = neg ? ((MW'(1) << PH_W) - {1'b0, ph}) : {1'b0, ph};
    mag_sh = mag >> shift;
    if (mag != '0 && mag_sh == '0) st = PH_W'(1);
    else                           st = mag_sh[PH_W-1:0];
    if (!apply)   delta = '0;
    else if (neg) delta = st;
    else          delta = ~st + PH_W'(1);
  end

endmodule

// File: rtl/bsync_phase.sv
module bsync_phase #(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_vld,
  input  logic            rx_in,
  input  logic [PH_W-1:0] delta,
  output logic [PH_W-1:0] ph_q,
  output logic            bit_stb,
  output logic            bit_data
);

  localparam logic [PH_W-1:0] CENTER = PH_W'(1) << (PH_W - 1);

  logic [PH_W-1:0] ph_d;
  logic            stb_d, data_d;

  always_comb begin
    ph_d   = ph_q;
    stb_d  = 1'b0;
    data_d = bit_data;
    if (smp_vld) begin
      ph_d = ph_q + PH_W'(1) + delta;
      if (ph_q == CENTER) begin
        stb_d  = 1'b1;
        data_d = rx_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= '0;
      bit_stb  <= 1'b0;
      bit_data <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      bit_stb  <= stb_d;
      bit_data <= data_d;
    end
  end

endmodule

// File: rtl/bsync_acq.sv
module bsync_acq
  import bsync_pkg::*;
#(
  parameter int ACQ_SNAP_N = 4,
  parameter int ACQ_STEP_N = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_we,
  input  logic [2:0]      ctl_wdata,
  input  logic            trn,
  output bw_e             bw_q,
  output logic            busy_q,
  output logic            apply,
  output logic [SH_W-1:0] shift
);

  localparam int NMAX  = (ACQ_SNAP_N > ACQ_STEP_N) ? ACQ_SNAP_N : ACQ_STEP_N;
  localparam int CNT_W = (NMAX > 1) ? $clog2(NMAX) : 1;
  localparam logic [CNT_W-1:0] SNAP_LAST = CNT_W'(ACQ_SNAP_N - 1);
  localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(ACQ_STEP_N - 1);

  bw_e             bw_d;
  logic            busy_d;
  logic [SH_W-1:0] sh_q, sh_d, tgt;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic            stage_end;

  always_comb begin
    tgt       = bw_shift(bw_q);
    stage_end = (sh_q == '0) ? (cnt_q == SNAP_LAST) : (cnt_q == STEP_LAST);
    bw_d      = bw_q;
    busy_d    = busy_q;
    sh_d      = sh_q;
    cnt_d     = cnt_q;
    if (busy_q && trn) begin
      if (stage_end) begin
        cnt_d = '0;
        sh_d  = sh_q + SH_W'(1);
        if (({1'b0, sh_q} + (SH_W+1)'(1)) >= {1'b0, tgt}) busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
    if (ctl_we) begin
      bw_d = bw_e'(ctl_wdata[1:0]);
      if (!ctl_wdata[2]) begin
        busy_d = 1'b1;
        sh_d   = '0;
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bw_q   <= BW_MEDIUM;
      busy_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      bw_q   <= bw_d;
      busy_q <= busy_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
    end
  end

  assign apply = trn && (busy_q || bw_q != BW_HOLD);
  assign shift = busy_q ? sh_q : tgt;

endmodule

// File: rtl/bsync_dpll.sv
module bsync_dpll
  import bsync_pkg::*;
#(
  parameter int PH_W       = 4,
  parameter int ACQ_SNAP_N = 4,
  parameter int ACQ_STEP_N = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_vld,
  input  logic       rx_in,
  input  logic       ctl_we,
  input  logic [2:0] ctl_wdata,
  output logic       bit_stb,
  output logic       bit_data,
  output logic       acq_busy
);

  logic [1:0]      rst_sync_q;
  logic            rst_s;
  logic            trn, apply;
  logic [SH_W-1:0] shift;
  logic [PH_W-1:0] delta, phase_q;
  bw_e             bw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  bsync_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_s),
    .smp_vld (smp_vld),
    .rx_in   (rx_in),
    .trn     (trn)
  );

  bsync_acq #(
    .ACQ_SNAP_N (ACQ_SNAP_N),
    .ACQ_STEP_N (ACQ_STEP_N)
  ) u_acq (
    .clk       (clk),
    .rst_n     (rst_s),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .trn       (trn),
    .bw_q      (bw_q),
    .busy_q    (acq_busy),
    .apply     (apply),
    .shift     (shift)
  );

  bsync_step #(
    .PH_W (PH_W),
    .SH_W (SH_W)
  ) u_step (
    .ph    (phase_q),
    .apply (apply),
    .shift (shift),
    .delta (delta)
  );

  bsync_phase #(
    .PH_W (PH_W)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_s),
    .smp_vld  (smp_vld),
    .rx_in    (rx_in),
    .delta    (delta),
    .ph_q     (phase_q),
    .bit_stb  (bit_stb),
    .bit_data (bit_data)
  );

endmodule

// File: rtl/bsync_dpll_chk.sv
module bsync_dpll_chk
  import bsync_pkg::*;
#(
  parameter int PH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_vld,
  input logic            ctl_we,
  input logic [2:0]      ctl_wdata,
  input logic            trn,
  input bw_e             bw,
  input logic [PH_W-1:0] ph,
  input logic            bit_stb,
  input logic            bit_data,
  input logic            acq_busy
);

  assert_stb_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

  assert_idle_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(ph));

  assert_data_on_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_data) |-> bit_stb);

  assert_hold_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !acq_busy && bw == BW_HOLD) |=> ph == PH_W'($past(ph) + PH_W'(1)));

  assert_acq_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[2]) |=> acq_busy);

  assert_idle_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[2] && !acq_busy) |=> !acq_busy);

  assert_busy_end_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acq_busy) |-> $past(trn));

endmodule

bind bsync_dpll bsync_dpll_chk #(.PH_W(PH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s),
  .smp_vld   (smp_vld),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .trn       (trn),
  .bw        (bw_q),
  .ph        (phase_q),
  .bit_stb   (bit_stb),
  .bit_data  (bit_data),
  .acq_busy  (acq_busy)
);

// File: tb/bsync_dpll_tb_top.sv
`timescale 1ns/1ps
module bsync_dpll_tb_top;

  logic       clk = 1'b0;
  logic       rst_n, smp_vld, rx_in, ctl_we;
  logic [2:0] ctl_wdata;
  logic       bit_stb, bit_data, acq_busy;
  logic       lvl;
  int         n_run  = 0;
  int         n_fail = 0;
  bit         done   = 0;

  always #4 clk = ~clk;

  bsync_dpll dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .rx_in     (rx_in),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .bit_stb   (bit_stb),
    .bit_data  (bit_data),
    .acq_busy  (acq_busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic smp(input logic r);
    smp_vld = 1'b1;
    rx_in   = r;
    @(posedge clk);
    #2;
    smp_vld = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] w);
    ctl_we    = 1'b1;
    ctl_wdata = w;
    @(posedge clk);
    #2;
    ctl_we = 1'b0;
  endtask

  // Feeds the current level until a strobe appears; returns samples used.
  task automatic run_to_stb(output int n);
    n = 0;
    do begin
      smp(lvl);
      n++;
    end while (!bit_stb && n < 40);
  endtask

  // Expected samples from the transition sample to the next strobe.
  function automatic int exp_gap(input int mode, input int p, input bit acq0);
    int e, mg, st, q;
    e = (p < 8) ? p : p - 16;
    if (acq0) st = e;
    else if (mode == 3) st = 0;
    else begin
      mg = ((e < 0) ? -e : e) >> ((mode == 1) ? 1 : (mode == 0) ? 2 : 3);
      if (mg == 0 && e != 0) mg = 1;
      st = (e < 0) ? -mg : mg;
    end
    q = (((p + 1 - st) % 16) + 16) % 16;
    return ((8 - q + 16) % 16) + 1;
  endfunction

  task automatic offset_edge(input int mode, input int d, input string req);
    int n;
    run_to_stb(n);
    repeat (d - 1) smp(lvl);
    lvl = ~lvl;
    smp(lvl);
    run_to_stb(n);
    check(n == exp_gap(mode, (8 + d) % 16, 1'b0), req, n, exp_gap(mode, (8 + d) % 16, 1'b0));
    check(bit_data == lvl, "R2", int'(bit_data), int'(lvl));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n, first;
    int acq_len [4];
    acq_len = '{12, 4, 20, 20};
    rst_n = 1'b0; smp_vld = 1'b0; rx_in = 1'b0; ctl_we = 1'b0; ctl_wdata = 3'b100;
    lvl = 1'b0;
    repeat (3) idle();
    check(bit_stb == 1'b0 && bit_data == 1'b0 && acq_busy == 1'b0, "R5 reset outputs",
          int'({bit_stb, bit_data, acq_busy}), 0);
    #1 rst_n = 1'b1;
    repeat (3) idle();
    check(acq_busy == 1'b0, "R5 busy after release", int'(acq_busy), 0);

    // R5: default bandwidth is medium; edge 4 samples after a strobe.
    offset_edge(0, 4, "R5 default medium");

    // R1: free run in hold, strobe period of 16 valid samples with idle gaps.
    wr(3'b111);
    run_to_stb(n);
    first = 0;
    for (int k = 1; k <= 16; k++) begin
      smp(lvl);
      if (bit_stb && first == 0) first = k;
      idle();
      check(bit_stb == 1'b0, "R1 no strobe on idle cycle", int'(bit_stb), 0);
    end
    check(first == 16, "R1 strobe period", first, 16);

    // R3/R4: all edge phases in all four bandwidth settings.
    for (int m = 0; m < 4; m++) begin
      wr({1'b1, 2'(m)});
      check(acq_busy == 1'b0, "R6 acquire bit 1 ignored", int'(acq_busy), 0);
      for (int d = 1; d <= 16; d++)
        offset_edge(m, d, (m == 3) ? "R4 hold sweep" : "R3 correction sweep");
    end

    // R7/R8/R9: acquisition per bandwidth setting.
    for (int m = 0; m < 4; m++) begin
      wr({1'b0, 2'(m)});
      check(acq_busy == 1'b1, "R6 acquire start", int'(acq_busy), 1);
      repeat (5) smp(lvl);
      lvl = ~lvl;
      smp(lvl);
      run_to_stb(n);
      check(n == 8, "R7 snap to edge", n, 8);
      repeat (7) smp(lvl);
      for (int i = 2; i <= acq_len[m]; i++) begin
        lvl = ~lvl;
        smp(lvl);
        if (i == acq_len[m] - 1)
          check(acq_busy == 1'b1, "R8 busy before last step", int'(acq_busy), 1);
        if (i == acq_len[m])
          check(acq_busy == 1'b0, "R8 busy ends on final transition", int'(acq_busy), 0);
        repeat (15) smp(lvl);
      end
      if (m == 3) begin
        repeat (4) smp(lvl);
        lvl = ~lvl;
        smp(lvl);
        run_to_stb(n);
        check(n == 4, "R9 hold after acquisition", n, 4);
      end
    end

    // R6: restart while busy.
    wr(3'b001);
    for (int i = 0; i < 3; i++) begin lvl = ~lvl; smp(lvl); repeat (9) smp(lvl); end
    check(acq_busy == 1'b1, "R6 busy mid acquisition", int'(acq_busy), 1);
    wr(3'b001);
    for (int i = 0; i < 3; i++) begin lvl = ~lvl; smp(lvl); repeat (9) smp(lvl); end
    check(acq_busy == 1'b1, "R6 restart resets count", int'(acq_busy), 1);
    lvl = ~lvl;
    smp(lvl);
    check(acq_busy == 1'b0, "R6 restarted sequence ends", int'(acq_busy), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule